// File: doc/BRIEF.md
# Sensor Limit Alarm Unit

This block watches digitized sensor readings and keeps latched alarm flags for them. It has up to five voltage channels, one temperature channel and two fan tachometer channels. Readings arrive as 8-bit words over a valid/ready sample stream, tagged with a channel number. A free-running update timer gives the refresh period. Accepted samples wait in a staging register until the next update, and only then become visible to the host. At that update they are also compared against programmable limits. A failed comparison sets a status bit, and that bit stays set until the host reads the status register that holds it.

One analog pin is shared. A mode input decides whether channel 4 is read as the fifth voltage or as a signed temperature. A separate input from external overtemperature sensors sets its own latched bit in every cycle it is high. The host writes limits through a plain write strobe and reads readings, limits and status through a read strobe with one cycle of latency.

On the sample stream, `smp_ready` is low for exactly one cycle per update period: the cycle in which staged values are committed. A sample offered in that cycle is held by the source and taken in the next cycle. A source may keep `smp_valid` high for as long as it likes. An accepted sample with a channel number of 7 or more is dropped.

Top module: `hwmon_alarm_unit`

## Requirements
- R1: `smp_ready` is low for exactly one cycle in every `UPD_CYCLES` cycles and high otherwise; a sample is accepted when `smp_valid` and `smp_ready` are both high.
- R2: Reading address 0x00+c returns the value of channel c as it stood at the last update; a sample accepted after that update is not visible until the next one. Status bits rise only at an update, except for the external bit.
- R3: Voltage channel k sets status A bit k at an update when its reading, compared unsigned, is above its maximum (0x10+k) or below its minimum (0x08+k); a reading equal to either limit sets nothing.
- R4: A status bit, once set, stays set even after its cause has gone, until the host reads its register (A at 0x20, B at 0x21); that read returns the set bit and then clears the register.
- R5: In temperature mode, status A bit 5 is set once when the signed reading first rises above the temperature maximum (0x18); while the reading stays above it, later updates do not set the bit again.
- R6: After such a rise, the bit is set again when the signed reading falls below the temperature minimum (0x19), and the detector re-arms for the next rise.
- R7: With `pin_temp_mode` high, channel 4 is the temperature and bit 4 is never set; with it low, channel 4 is a voltage and bit 5 is never set.
- R8: Fan j (channel 5+j) sets status A bit 6+j at an update when its period count is above its limit (0x1A+j); an equal count sets nothing.
- R9: `ext_ot` high at a clock edge sets status B bit 0, independent of the update timer.
- R10: When a bit is set in the same cycle as its register is read, the set wins, and the next read still returns the bit.
- R11: The limit registers read back what was written. Their reset values are: voltage minimum 0x00, voltage maximum 0xFF, temperature maximum 0x7F, temperature minimum 0x80, fan limit 0xFF.
- R12: `rd_valid` and `rd_data` come one cycle after `rd_en`.
- R13: After reset, all readings and both status registers read zero and `smp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample word offered |
| smp_ready | output | 1 | Sample stream can accept |
| smp_chan | input | 3 | Channel number of the sample |
| smp_data | input | 8 | Sample value |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_addr | input | 6 | Write address |
| cfg_wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 6 | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| ext_ot | input | 1 | External overtemperature indication |
| pin_temp_mode | input | 1 | Shared pin is temperature (1) or fifth voltage (0) |

## Verification
Most wrong internal state first shows on the status registers, at the next update. A stale or wrongly routed staging register gives a missing or extra alarm bit, or a reading that comes back wrong, within one update period. A temperature detector stuck in the wrong state shows as a repeated or missing bit 5 on the next two status reads. A clear with the wrong priority shows as a lost external bit on the read after the event. A timer fault appears at once on `smp_ready`, as a wrong spacing of its low cycles.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_RD   = 6'h00;
  localparam logic [AW-1:0] A_VMIN = 6'h08;
  localparam logic [AW-1:0] A_VMAX = 6'h10;
  localparam logic [AW-1:0] A_TMAX = 6'h18;
  localparam logic [AW-1:0] A_TMIN = 6'h19;
  localparam logic [AW-1:0] A_FLIM = 6'h1A;
  localparam logic [AW-1:0] A_STA  = 6'h20;
  localparam logic [AW-1:0] A_STB  = 6'h21;

  typedef enum logic {TEMP_ARMED = 1'b0, TEMP_TRIPPED = 1'b1} temp_state_e;
endpackage

// File: rtl/hwmon_update_timer.sv
module hwmon_update_timer #(
  parameter int unsigned PERIOD = 75_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hwmon_sample_stage.sv
module hwmon_sample_stage #(
  parameter int N_CH = 7,
  parameter int DW   = 8,
  parameter int CHW  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      valid,
  output logic                      ready,
  input  logic [CHW-1:0]            chan,
  input  logic [DW-1:0]             data,
  output logic [N_CH-1:0][DW-1:0]   staged,
  output logic [N_CH-1:0][DW-1:0]   held
);
  logic take;

  assign ready = !tick;
  assign take  = valid && ready;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged[i] <= '0;
        held[i]   <= '0;
      end else begin
        if (take && (chan == CHW'(i))) staged[i] <= data;
        if (tick) held[i] <= staged[i];
      end
    end
  end
endmodule

// File: rtl/hwmon_limit_regs.sv
module hwmon_limit_regs
  import hwmon_pkg::*;
#(
  parameter int N_VOLT = 5,
  parameter int N_FAN  = 2,
  parameter int DW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [DW-1:0]             wdata,
  output logic [N_VOLT-1:0][DW-1:0] vmin,
  output logic [N_VOLT-1:0][DW-1:0] vmax,
  output logic [DW-1:0]             tmax,
  output logic [DW-1:0]             tmin,
  output logic [N_FAN-1:0][DW-1:0]  flim
);
  localparam logic [DW-1:0] TMAX_RST = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] TMIN_RST = {1'b1, {(DW-1){1'b0}}};

  for (genvar k = 0; k < N_VOLT; k++) begin : g_volt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vmin[k] <= '0;
        vmax[k] <= '1;
      end else if (we) begin
        if (waddr == A_VMIN + AW'(k)) vmin[k] <= wdata;
        if (waddr == A_VMAX + AW'(k)) vmax[k] <= wdata;
      end
    end
  end

  for (genvar j = 0; j < N_FAN; j++) begin : g_fan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              flim[j] <= '1;
      else if (we && waddr == A_FLIM + AW'(j)) flim[j] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmax <= TMAX_RST;
      tmin <= TMIN_RST;
    end else if (we) begin
      if (waddr == A_TMAX) tmax <= wdata;
      if (waddr == A_TMIN) tmin <= wdata;
    end
  end
endmodule

// File: rtl/hwmon_limit_cmp.sv
module hwmon_limit_cmp
  import hwmon_pkg::*;
#(
  parameter int N_VOLT = 5,
  parameter int N_FAN  = 2,
  parameter int DW     = 8,
  localparam int N_CH  = N_VOLT + N_FAN,
  localparam int NA    = N_VOLT + 1 + N_FAN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      temp_mode,
  input  logic [N_CH-1:0][DW-1:0]   staged,
  input  logic [N_VOLT-1:0][DW-1:0] vmin,
  input  logic [N_VOLT-1:0][DW-1:0] vmax,
  input  logic [DW-1:0]             tmax,
  input  logic [DW-1:0]             tmin,
  input  logic [N_FAN-1:0][DW-1:0]  flim,
  output logic [NA-1:0]             evt
);
  localparam int SHARED = N_VOLT - 1;
  localparam int T_BIT  = N_VOLT;

  logic [NA-1:0] raw;

  // voltage windows, unsigned; the shared pin only counts in voltage mode
  for (genvar k = 0; k < N_VOLT; k++) begin : g_volt
    logic out_of_win;
    assign out_of_win = (staged[k] > vmax[k]) || (staged[k] < vmin[k]);
    if (k == SHARED) begin : g_shared
      assign raw[k] = out_of_win && !temp_mode;
    end else begin : g_plain
      assign raw[k] = out_of_win;
    end
  end

  // fan period counts: a longer period than the limit means too slow
  for (genvar j = 0; j < N_FAN; j++) begin : g_fan
    assign raw[T_BIT + 1 + j] = staged[N_VOLT + j] > flim[j];
  end

  // temperature: signed, fires on rise above max and on fall below min
  temp_state_e t_state, t_state_nx;
  logic        t_over, t_under, t_fire;

  assign t_over  = $signed(staged[SHARED]) > $signed(tmax);
  assign t_under = $signed(staged[SHARED]) < $signed(tmin);

  always_comb begin
    t_state_nx = t_state;
    t_fire     = 1'b0;
    if (!temp_mode) begin
      t_state_nx = TEMP_ARMED;
    end else begin
      unique case (t_state)
        TEMP_ARMED: if (t_over) begin
          t_fire     = 1'b1;
          t_state_nx = TEMP_TRIPPED;
        end
        TEMP_TRIPPED: if (t_under) begin
          t_fire     = 1'b1;
          t_state_nx = TEMP_ARMED;
        end
        default: t_state_nx = TEMP_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_state <= TEMP_ARMED;
    else if (tick) t_state <= t_state_nx;
  end

  assign raw[T_BIT] = t_fire;
  assign evt        = raw & {NA{tick}};
endmodule

// File: rtl/hwmon_alarm_status.sv
module hwmon_alarm_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] stat
);
  // a new event in the clearing cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~{W{clr}}) | set;
  end
endmodule

// File: rtl/hwmon_alarm_unit.sv
module hwmon_alarm_unit
  import hwmon_pkg::*;
#(
  parameter int          N_VOLT     = 5,
  parameter int          N_FAN      = 2,
  parameter int          DW         = 8,
  parameter int unsigned UPD_CYCLES = 75_000_000,
  localparam int N_CH = N_VOLT + N_FAN,
  localparam int CHW  = $clog2(N_CH),
  localparam int NA   = N_VOLT + 1 + N_FAN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [CHW-1:0]  smp_chan,
  input  logic [DW-1:0]   smp_data,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic            ext_ot,
  input  logic            pin_temp_mode
);
  logic                      upd_tick;
  logic [N_CH-1:0][DW-1:0]   staged;
  logic [N_CH-1:0][DW-1:0]   held;
  logic [N_VOLT-1:0][DW-1:0] vmin, vmax;
  logic [DW-1:0]             tmax, tmin;
  logic [N_FAN-1:0][DW-1:0]  flim;
  logic [NA-1:0]             evt_a;
  logic [NA-1:0]             stat_a;
  logic [0:0]                stat_b;
  logic                      clr_a, clr_b;
  logic [DW-1:0]             rd_mux;

  hwmon_update_timer #(.PERIOD(UPD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick)
  );

  hwmon_sample_stage #(.N_CH(N_CH), .DW(DW), .CHW(CHW)) u_stage (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick),
    .valid(smp_valid), .ready(smp_ready), .chan(smp_chan), .data(smp_data),
    .staged(staged), .held(held)
  );

  hwmon_limit_regs #(.N_VOLT(N_VOLT), .N_FAN(N_FAN), .DW(DW)) u_limits (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .vmin(vmin), .vmax(vmax), .tmax(tmax), .tmin(tmin), .flim(flim)
  );

  hwmon_limit_cmp #(.N_VOLT(N_VOLT), .N_FAN(N_FAN), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(upd_tick), .temp_mode(pin_temp_mode),
    .staged(staged), .vmin(vmin), .vmax(vmax), .tmax(tmax), .tmin(tmin),
    .flim(flim), .evt(evt_a)
  );

  assign clr_a = rd_en && (rd_addr == A_STA);
  assign clr_b = rd_en && (rd_addr == A_STB);

  hwmon_alarm_status #(.W(NA)) u_stat_a (
    .clk(clk), .rst_n(rst_n), .set(evt_a), .clr(clr_a), .stat(stat_a)
  );

  hwmon_alarm_status #(.W(1)) u_stat_b (
    .clk(clk), .rst_n(rst_n), .set(ext_ot), .clr(clr_b), .stat(stat_b)
  );

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < N_CH; c++)
      if (rd_addr == A_RD + AW'(c)) rd_mux = held[c];
    for (int k = 0; k < N_VOLT; k++) begin
      if (rd_addr == A_VMIN + AW'(k)) rd_mux = vmin[k];
      if (rd_addr == A_VMAX + AW'(k)) rd_mux = vmax[k];
    end
    for (int j = 0; j < N_FAN; j++)
      if (rd_addr == A_FLIM + AW'(j)) rd_mux = flim[j];
    if (rd_addr == A_TMAX) rd_mux = tmax;
    if (rd_addr == A_TMIN) rd_mux = tmin;
    if (rd_addr == A_STA)  rd_mux = DW'(stat_a);
    if (rd_addr == A_STB)  rd_mux = DW'(stat_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/hwmon_alarm_chk.sv
module hwmon_alarm_chk
  import hwmon_pkg::*;
#(
  parameter int N_VOLT = 5,
  parameter int N_CH   = 7,
  parameter int NA     = 8,
  parameter int DW     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_ready,
  input logic                    upd_tick,
  input logic                    rd_en,
  input logic [AW-1:0]           rd_addr,
  input logic                    rd_valid,
  input logic                    ext_ot,
  input logic                    pin_temp_mode,
  input logic [N_CH-1:0][DW-1:0] held,
  input logic [NA-1:0]           stat_a,
  input logic [0:0]              stat_b
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_ready |=> smp_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_tick |=> $stable(held));

  assert_rise_on_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_tick |=> ((stat_a & ~$past(stat_a)) == '0));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == A_STA) |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

  assert_mode_temp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && pin_temp_mode) |=> !(stat_a[N_VOLT-1] && !$past(stat_a[N_VOLT-1])));

  assert_mode_volt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && !pin_temp_mode) |=> !(stat_a[N_VOLT] && !$past(stat_a[N_VOLT])));

  assert_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ot |=> stat_b[0]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ot && rd_en && rd_addr == A_STB) |=> stat_b[0]);

  assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

bind hwmon_alarm_unit hwmon_alarm_chk #(
  .N_VOLT(N_VOLT), .N_CH(N_CH), .NA(NA), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_ready(smp_ready), .upd_tick(upd_tick),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .ext_ot(ext_ot),
  .pin_temp_mode(pin_temp_mode), .held(held), .stat_a(stat_a), .stat_b(stat_b)
);

// File: tb/tb_hwmon_alarm_unit.sv
module tb_hwmon_alarm_unit;
  localparam int UPD = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [2:0] smp_chan = '0;
  logic [7:0] smp_data = '0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       ext_ot = 1'b0;
  logic       pin_temp_mode = 1'b0;

  always #10 clk = ~clk;

  hwmon_alarm_unit #(.UPD_CYCLES(UPD)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_chan(smp_chan), .smp_data(smp_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .ext_ot(ext_ot), .pin_temp_mode(pin_temp_mode)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [5:0] adr_q[$];
  string      tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // monitor: compares read results against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected rd_valid", 1, 0);
      end else begin
        logic [7:0] e;
        logic [5:0] a;
        string t;
        e = exp_q.pop_front();
        a = adr_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, $sformatf("%s addr %0h", t, a), rd_data, e);
      end
    end
  end

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); adr_q.push_back(a); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [2:0] ch, input logic [7:0] d);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // returns just after the update edge
  task automatic wait_update();
    @(negedge clk);
    while (smp_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_ready === 1'b1, "R13 ready after reset", smp_ready, 1);
    rd(6'h20, 8'h00, "R13 status A reset");
    rd(6'h21, 8'h00, "R13 status B reset");
    rd(6'h00, 8'h00, "R13 reading reset");
    rd(6'h10, 8'hFF, "R11 vmax reset");
    rd(6'h08, 8'h00, "R11 vmin reset");
    rd(6'h18, 8'h7F, "R11 tmax reset");
    rd(6'h19, 8'h80, "R11 tmin reset");
    rd(6'h1B, 8'hFF, "R11 fan limit reset");

    // R1: spacing of the ready-low cycles
    @(negedge clk);
    while (smp_ready) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (smp_ready) @(negedge clk);
    check((cyc - t0) == UPD, "R1 update spacing", cyc - t0, UPD);

    // stage samples, then program limits
    wait_update();
    send(3'd0, 8'hC1);
    send(3'd1, 8'h3F);
    send(3'd2, 8'hC0);
    send(3'd3, 8'h40);
    send(3'd4, 8'h80);
    send(3'd5, 8'h81);
    send(3'd6, 8'h80);
    for (int k = 0; k < 5; k++) begin
      wr(6'h08 + 6'(k), 8'h40);
      wr(6'h10 + 6'(k), 8'hC0);
    end
    wr(6'h1A, 8'h80);
    wr(6'h1B, 8'h80);
    wr(6'h18, 8'd50);
    wr(6'h19, 8'd40);
    wait_update();
    rd(6'h00, 8'hC1, "R2 reading ch0 after update");
    rd(6'h05, 8'h81, "R2 reading fan0 after update");
    send(3'd0, 8'h80);
    send(3'd1, 8'h80);
    send(3'd5, 8'h10);
    rd(6'h00, 8'hC1, "R2 old value before update");
    wait_update();
    rd(6'h20, 8'h43, "R4 R3 R8 sticky status after cause gone");
    rd(6'h20, 8'h00, "R4 cleared by read");
    rd(6'h00, 8'h80, "R2 new value after update");
    rd(6'h08, 8'h40, "R11 vmin readback");
    rd(6'h18, 8'd50, "R11 tmax readback");
    rd(6'h1A, 8'h80, "R11 fan limit readback");

    // temperature mode
    pin_temp_mode = 1'b1;
    send(3'd4, 8'd51);
    wait_update();
    rd(6'h20, 8'h20, "R5 R7 rise above max, no bit4");
    rd(6'h04, 8'd51, "R2 shared pin reading");
    wait_update();
    rd(6'h20, 8'h00, "R5 no re-raise while above");
    send(3'd4, 8'd45);
    wait_update();
    rd(6'h20, 8'h00, "R6 between limits no event");
    send(3'd4, 8'hC4);
    wait_update();
    rd(6'h20, 8'h20, "R6 signed fall below min");
    wait_update();
    rd(6'h20, 8'h00, "R6 no repeat after fall");

    // voltage mode on the shared pin, same code out of window
    pin_temp_mode = 1'b0;
    wait_update();
    rd(6'h20, 8'h10, "R7 voltage mode bit4 only");
    send(3'd4, 8'h80);
    wait_update();
    rd(6'h20, 8'h00, "R7 cleared, in window");

    // external overtemperature
    rd(6'h21, 8'h00, "R9 before pulse");
    @(negedge clk);
    ext_ot = 1'b1;
    @(negedge clk);
    ext_ot = 1'b0;
    rd(6'h21, 8'h01, "R9 latched after pulse");
    rd(6'h21, 8'h00, "R9 cleared by read");
    rd(6'h20, 8'h00, "R9 status A untouched");

    // set and clear in the same cycle
    @(negedge clk);
    ext_ot = 1'b1;
    rd(6'h21, 8'h01, "R10 read while set");
    ext_ot = 1'b0;
    rd(6'h21, 8'h01, "R10 set survived clear");
    rd(6'h21, 8'h00, "R10 final clear");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule